// File: doc/BRIEF.md
# 128-bit Lane Permutation Unit

This block rearranges the 32-bit words, 16-bit halfwords and bytes of two 128-bit source operands into one 128-bit result for a SIMD execution pipe. Each request arrives as a one-cycle strobe. The strobe carries a 4-bit operation code, two source register indices with their data, and a destination register index. The unit covers the irregular cross-lane moves that a lane-parallel ALU cannot do: word packing, interleaving of low or high halves at three element widths, halfword broadcast, doubleword copies, and a three-word rotation.

A source index of zero stands for the hard-wired zero register. Its data input is then ignored and read as all zeros. A destination index of zero, or an operation code that has no meaning, makes the request a no-op. In that case no valid pulse is raised and the held result does not change. A request that does write is registered. It appears on the output, tagged with its destination index, in the cycle after the strobe.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` means the output register holds a fresh result and `res_valid` is high. The transitions are:
- `ST_IDLE` to `ST_EMIT` on a writing strobe (TO_EMIT).
- `ST_EMIT` stays in `ST_EMIT` on a writing strobe (RE_EMIT).
- `ST_EMIT` returns to `ST_IDLE` on any other cycle (DRAIN).
- `ST_IDLE` stays in `ST_IDLE` otherwise (IDLE_HOLD).

Top module: `lane_perm_unit`

## Requirements
- R1: After reset `res_valid` is 0, `res_rd` is 0 and `res_data` is 0.
- R2: Op code 0 (word pack) gives result words 0..3 equal to B word 0, B word 2, A word 0, A word 2. Here A is the first source and B the second, and word k is bits 32k+31:32k.
- R3: Op codes 1, 2 and 3 interleave the low 64 bits of both sources at 8-, 16- and 32-bit element width respectively. Result element 2i is B element i and result element 2i+1 is A element i, counting from the least significant element.
- R4: Op code 4 applies the 32-bit interleave of R3 to the upper 64-bit halves (bits 127:64) of A and B.
- R5: Op code 5 copies bits 15:0 of B into all four halfwords of result bits 63:0, and copies bits 79:64 of B into all four halfwords of result bits 127:64.
- R6: Op code 6 gives result bits 63:0 equal to B bits 63:0 and result bits 127:64 equal to A bits 63:0.
- R7: Op code 7 gives result bits 63:0 equal to A bits 127:64 and result bits 127:64 equal to B bits 127:64.
- R8: Op code 8, with B words w0..w3, gives result words 0..3 equal to w1, w2, w0, w3, so the top word is unchanged.
- R9: When a source index is 0, that source's data input is ignored and read as all zeros.
- R10: A strobe with destination index 0, or with an op code from 9 to 15, raises no valid pulse and leaves `res_data` and `res_rd` unchanged.
- R11: A writing strobe in cycle n gives `res_valid` high in cycle n+1, with `res_rd` equal to the strobe's destination index. `res_valid` is low in any cycle that does not follow a writing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 4 | Operation code (0..8 defined) |
| req_a_idx | input | IDX_W | First source register index |
| req_b_idx | input | IDX_W | Second source register index |
| req_rd | input | IDX_W | Destination register index |
| req_a_data | input | 128 | First source data |
| req_b_data | input | 128 | Second source data |
| res_valid | output | 1 | Result valid pulse |
| res_rd | output | IDX_W | Destination index of the result |
| res_data | output | 128 | Permuted result |

## Verification
The bench sweeps all sixteen op codes against four data patterns. Each pattern is run with every combination of zero and non-zero source indices and zero and non-zero destination. A design that swapped the even and odd interleave sources, or shuffled element order, would fail the extend checks at the width where its error shows. A rotation that moved the top word would fail R8. A unit that read source data behind index zero would show non-zero words. The no-op sweep catches a valid pulse, or a result overwrite, on destination zero or on unused codes. Back-to-back strobes catch a valid that fails to stay high across consecutive writes, or a valid that stays high one cycle too long.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
    localparam int QW_W   = 128;
    localparam int HALF_W = QW_W / 2;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        OP_PACK_W   = 4'd0,
        OP_EXTLO_B  = 4'd1,
        OP_EXTLO_H  = 4'd2,
        OP_EXTLO_W  = 4'd3,
        OP_EXTHI_W  = 4'd4,
        OP_BCAST_H  = 4'd5,
        OP_COPY_LO  = 4'd6,
        OP_COPY_HI  = 4'd7,
        OP_ROT3_W   = 4'd8
    } perm_op_e;

    localparam logic [3:0] OP_LAST = 4'd8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } perm_state_e;
endpackage

// File: rtl/perm_src_gate.sv
module perm_src_gate #(
    parameter int IDX_W = 5,
    parameter int DW    = 128
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    raw,
    output logic [DW-1:0]    gated
);
    // index zero is the hard-wired zero register
    assign gated = (idx == '0) ? '0 : raw;
endmodule

// File: rtl/perm_interleave.sv
module perm_interleave #(
    parameter int EW = 8,
    parameter int HW = 64
) (
    input  logic [HW-1:0]   even_src,
    input  logic [HW-1:0]   odd_src,
    output logic [2*HW-1:0] mixed
);
    localparam int N_EL = HW / EW;

    for (genvar i = 0; i < N_EL; i++) begin : g_el
        assign mixed[(2*i)*EW   +: EW] = even_src[i*EW +: EW];
        assign mixed[(2*i+1)*EW +: EW] = odd_src[i*EW +: EW];
    end
endmodule

// File: rtl/perm_shuffle.sv
module perm_shuffle
    import lane_perm_pkg::*;
(
    input  logic [3:0]      op,
    input  logic [QW_W-1:0] src_a,
    input  logic [QW_W-1:0] src_b,
    output logic [QW_W-1:0] result,
    output logic            op_ok
);
    localparam int HW = HALF_W;

    logic [QW_W-1:0] ilv_lo [3];
    logic [QW_W-1:0] ilv_hi_w;

    for (genvar g = 0; g < 3; g++) begin : g_lo
        perm_interleave #(.EW(8 << g), .HW(HW)) u_ilv (
            .even_src (src_b[HW-1:0]),
            .odd_src  (src_a[HW-1:0]),
            .mixed    (ilv_lo[g])
        );
    end

    perm_interleave #(.EW(WORD_W), .HW(HW)) u_ilv_hi (
        .even_src (src_b[QW_W-1:HW]),
        .odd_src  (src_a[QW_W-1:HW]),
        .mixed    (ilv_hi_w)
    );

    always_comb begin
        result = '0;
        op_ok  = 1'b1;
        unique case (op)
            OP_PACK_W:  result = {src_a[95:64], src_a[31:0], src_b[95:64], src_b[31:0]};
            OP_EXTLO_B: result = ilv_lo[0];
            OP_EXTLO_H: result = ilv_lo[1];
            OP_EXTLO_W: result = ilv_lo[2];
            OP_EXTHI_W: result = ilv_hi_w;
            OP_BCAST_H: result = {{4{src_b[79:64]}}, {4{src_b[15:0]}}};
            OP_COPY_LO: result = {src_a[HW-1:0], src_b[HW-1:0]};
            OP_COPY_HI: result = {src_b[QW_W-1:HW], src_a[QW_W-1:HW]};
            OP_ROT3_W:  result = {src_b[127:96], src_b[31:0], src_b[95:64], src_b[63:32]};
            default: begin
                result = '0;
                op_ok  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
    import lane_perm_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [IDX_W-1:0] req_a_idx,
    input  logic [IDX_W-1:0] req_b_idx,
    input  logic [IDX_W-1:0] req_rd,
    input  logic [127:0]     req_a_data,
    input  logic [127:0]     req_b_data,
    output logic             res_valid,
    output logic [IDX_W-1:0] res_rd,
    output logic [127:0]     res_data
);
    logic [QW_W-1:0] a_eff, b_eff, shuf;
    logic            op_ok, do_write;
    perm_state_e     state_q, state_d;

    perm_src_gate #(.IDX_W(IDX_W), .DW(QW_W)) u_gate_a (
        .idx (req_a_idx), .raw (req_a_data), .gated (a_eff)
    );
    perm_src_gate #(.IDX_W(IDX_W), .DW(QW_W)) u_gate_b (
        .idx (req_b_idx), .raw (req_b_data), .gated (b_eff)
    );

    perm_shuffle u_shuf (
        .op     (req_op),
        .src_a  (a_eff),
        .src_b  (b_eff),
        .result (shuf),
        .op_ok  (op_ok)
    );

    assign do_write = req_valid && op_ok && (req_rd != '0);

    // next-state: TO_EMIT, RE_EMIT, DRAIN, IDLE_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = do_write ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = do_write ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_rd   <= '0;
            res_data <= '0;
        end else if (do_write) begin
            res_rd   <= req_rd;
            res_data <= shuf;
        end
    end

    assign res_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/lane_perm_chk.sv
module lane_perm_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [3:0]       req_op,
    input logic [IDX_W-1:0] req_b_idx,
    input logic [IDX_W-1:0] req_rd,
    input logic [127:0]     req_b_data,
    input logic             res_valid,
    input logic [IDX_W-1:0] res_rd,
    input logic [127:0]     res_data
);
    logic wr_req;
    assign wr_req = req_valid && (req_rd != '0) && (req_op <= 4'd8);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> res_valid); // R11
    AST_RD_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (res_rd == $past(req_rd))); // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !res_valid); // R10
    AST_HOLD_ON_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> ($stable(res_data) && $stable(res_rd))); // R10
    AST_ROT_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_op == 4'd8 && req_b_idx != '0)
        |=> (res_data[127:96] == $past(req_b_data[127:96]))); // R8
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_op == 4'd8 && req_b_idx == '0) |=> (res_data == '0)); // R9
endmodule

bind lane_perm_unit lane_perm_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_b_idx  (req_b_idx),
    .req_rd     (req_rd),
    .req_b_data (req_b_data),
    .res_valid  (res_valid),
    .res_rd     (res_rd),
    .res_data   (res_data)
);

// File: tb/tb_lane_perm_unit.sv
module tb_lane_perm_unit;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_op = '0;
    logic [IDX_W-1:0] req_a_idx = '0, req_b_idx = '0, req_rd = '0;
    logic [127:0]     req_a_data = '0, req_b_data = '0;
    logic             res_valid;
    logic [IDX_W-1:0] res_rd;
    logic [127:0]     res_data;

    int checks = 0;
    int fails  = 0;

    logic [127:0]     held_data = '0;
    logic [IDX_W-1:0] held_rd = '0;

    always #10 clk = ~clk;

    lane_perm_unit #(.IDX_W(IDX_W)) dut (.*);

    function automatic logic [127:0] pattern(input int p, input int salt);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) begin
            case (p)
                0: v[k*8 +: 8] = 8'(k + 16 * salt + 1);
                1: v[k*8 +: 8] = 8'((k * 37 + salt * 91) ^ 8'h5a);
                2: v[k*8 +: 8] = 8'hff;
                default: v[k*8 +: 8] = (k[0] ^ salt[0]) ? 8'ha5 : 8'h3c;
            endcase
        end
        return v;
    endfunction

    function automatic logic [127:0] model(input int op, input logic [127:0] a,
                                           input logic [127:0] b);
        logic [127:0] r;
        int w, base, el;
        r = '0;
        case (op)
            0: for (int j = 0; j < 128; j++) begin
                   // words: 0<-b0, 1<-b2, 2<-a0, 3<-a2
                   el = j / 32;
                   r[j] = (el < 2) ? b[(el * 2) * 32 + j % 32] : a[((el - 2) * 2) * 32 + j % 32];
               end
            1, 2, 3, 4: begin
                w    = (op == 1) ? 8 : (op == 2) ? 16 : 32;
                base = (op == 4) ? 64 : 0;
                for (int j = 0; j < 128; j++) begin
                    el = j / w;
                    r[j] = (el % 2 == 1) ? a[base + (el / 2) * w + j % w]
                                         : b[base + (el / 2) * w + j % w];
                end
            end
            5: for (int j = 0; j < 128; j++) r[j] = b[(j / 64) * 64 + j % 16];
            6: for (int j = 0; j < 128; j++) r[j] = (j < 64) ? b[j] : a[j - 64];
            7: for (int j = 0; j < 128; j++) r[j] = (j < 64) ? a[j + 64] : b[j];
            8: for (int j = 0; j < 128; j++) begin
                   el = j / 32;
                   r[j] = b[((el == 0) ? 1 : (el == 1) ? 2 : (el == 2) ? 0 : 3) * 32 + j % 32];
               end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";
            1, 2, 3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic one_req(input int op, input int ai, input int bi, input int rd,
                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] ea, eb, exp;
        bit wr;
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'(op);
        req_a_idx = IDX_W'(ai); req_b_idx = IDX_W'(bi); req_rd = IDX_W'(rd);
        req_a_data = a; req_b_data = b;
        @(negedge clk);
        req_valid = 1'b0;
        ea = (ai == 0) ? '0 : a;   // R9 zero register
        eb = (bi == 0) ? '0 : b;
        wr = (rd != 0) && (op <= 8);
        if (wr) begin
            exp = model(op, ea, eb);
            check(res_valid === 1'b1, "R11", "valid", 128'(res_valid), 128'd1);
            check(res_rd === IDX_W'(rd), "R11", "rd", 128'(res_rd), 128'(rd));
            check(res_data === exp, (ai == 0 || bi == 0) ? "R9" : req_of(op), "data",
                  res_data, exp);
            held_data = exp; held_rd = IDX_W'(rd);
        end else begin
            check(res_valid === 1'b0, "R10", "no pulse", 128'(res_valid), 128'd0);
            check(res_data === held_data && res_rd === held_rd, "R10", "held",
                  res_data, held_data);
        end
        @(negedge clk);
        check(res_valid === 1'b0, "R11", "pulse ends", 128'(res_valid), 128'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [127:0] exp1, exp2;
        repeat (3) @(negedge clk);
        check(res_valid === 1'b0 && res_rd === '0 && res_data === '0, "R1", "reset",
              res_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, "R1", "idle after reset", 128'(res_valid), 128'd0);

        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 16; op++)
                for (int c = 0; c < 8; c++)
                    one_req(op, c[0] ? 3 : 0, c[1] ? 7 : 0, c[2] ? 9 : 0,
                            pattern(p, 0), pattern(p, 1));

        // back-to-back writes: R11 valid stays high, second result follows
        exp1 = model(3, pattern(1, 0), pattern(1, 1));
        exp2 = model(8, pattern(0, 0), pattern(0, 1));
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd3; req_a_idx = 5'd1; req_b_idx = 5'd2; req_rd = 5'd4;
        req_a_data = pattern(1, 0); req_b_data = pattern(1, 1);
        @(negedge clk);
        check(res_valid === 1'b1 && res_data === exp1 && res_rd === 5'd4, "R11",
              "b2b first", res_data, exp1);
        req_op = 4'd8; req_rd = 5'd31; req_a_data = pattern(0, 0); req_b_data = pattern(0, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(res_valid === 1'b1 && res_data === exp2 && res_rd === 5'd31, "R11",
              "b2b second", res_data, exp2);
        @(negedge clk);
        check(res_valid === 1'b0 && res_data === exp2, "R11", "b2b drain", res_data, exp2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule